// File: doc/BRIEF.md
# Byte-Access Bridge for 16-bit Timer Registers

This block sits between an 8-bit CPU bus and the 16-bit registers of one timer: the live counter, a capture register and a parameterised number of compare registers. A CPU moves every 16-bit value as two byte accesses. One 8-bit holding register is shared by the whole register group. It ensures that a 16-bit value is always taken or committed in a single clock edge, even though the CPU moves it in two halves.

Writes must send the high byte first. That byte waits in the holding register. The low-byte write then commits both bytes at once. Reads must take the low byte first. For the counter and the capture register, reading the low byte also copies the matching high byte into the holding register, so the high-byte read that follows returns a consistent snapshot. The compare registers are plain storage, so both of their bytes are read straight from the register and the holding register is left alone.

The counter itself lives outside the block. Its value arrives on a live input. A committed counter write is passed on as a one-cycle load request.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, the holding register, the capture register and every compare register are zero, and no counter load is requested.
- R2: The address is {register index, byte select}. Byte select bit 0 = 1 means the high byte. Index 0 is the counter, index 1 is the capture register, and index 2+k is compare register k. A high-byte write changes only the holding register; no 16-bit register changes.
- R3: A low-byte write to the capture register or to a compare register loads {holding byte, written byte} into it at that clock edge. A low-byte write to the counter drives cnt_load_o high in that cycle, with cnt_load_val_o = {holding byte, written byte}.
- R4: A low-byte read of the counter returns cnt_i[7:0] and stores cnt_i[15:8] in the holding register at that edge. A later high-byte read returns that stored byte, even if cnt_i has changed since.
- R5: A low-byte read of the capture register returns its low byte and copies its high byte into the holding register. A high-byte read of the counter or of the capture register returns the holding register.
- R6: Both bytes of a compare register are read directly from that register, and reading a compare register leaves the holding register unchanged.
- R7: The holding register is shared. A high byte written at any index is the one used by the next low-byte write to any other register.
- R8: The holding register keeps its value after a low-byte write, so several low-byte writes in a row reuse the same high byte.
- R9: An index with no register behind it reads as 0x00. Writes to such an index change neither the holding register nor any 16-bit register.
- R10: When read and write strobes are both high in one cycle, the write takes effect and the read does not update the holding register. rdata_o is 0x00 whenever rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | ADDR_W | {register index, byte select} |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid in the strobe cycle |
| cnt_i | input | 16 | Live counter value |
| cnt_load_o | output | 1 | Counter load request |
| cnt_load_val_o | output | 16 | Value to load into the counter |
| cap_o | output | 16 | Capture register contents |
| cmp_o | output | NUM_CMP*16 | Compare registers, register k at bits [16k+15:16k] |

## Verification
The bench builds the block with three compare registers. That gives a 4-bit address with eight indices, and the top three indices have no register behind them. Every index and both byte selects can therefore be swept, out-of-range addresses included. A long run of pseudo-random accesses, with strobes overlapping now and then, is compared against an arithmetic model of the holding register and register contents. Directed sequences cover the counter snapshot while the live count moves, and a high byte written at one index being used by a low-byte write at another.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    KIND_CNT  = 2'd0,
    KIND_CAP  = 2'd1,
    KIND_CMP  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode
  import wrb_pkg::*;
#(
  parameter int unsigned NUM_CMP = 3,
  parameter int unsigned ADDR_W  = 4,
  localparam int unsigned IDX_W  = ADDR_W - 1
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output reg_kind_e          kind_o,
  output logic               hi_o,
  output logic [NUM_CMP-1:0] cmp_sel_o
);
  logic [IDX_W-1:0] idx;

  assign idx  = addr_i[ADDR_W-1:1];
  assign hi_o = addr_i[0];

  always_comb begin
    if (int'(idx) == 0)                kind_o = KIND_CNT;
    else if (int'(idx) == 1)           kind_o = KIND_CAP;
    else if (int'(idx) < NUM_CMP + 2)  kind_o = KIND_CMP;
    else                               kind_o = KIND_NONE;
  end

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_sel
    assign cmp_sel_o[k] = (int'(idx) == k + 2);
  end
endmodule

// File: rtl/wrb_temp_reg.sv
module wrb_temp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/wrb_store.sv
module wrb_store #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int unsigned NUM_CMP  = 3,
  localparam int unsigned NUM_REG = NUM_CMP + 2,
  localparam int unsigned ADDR_W  = $clog2(NUM_REG) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  output logic [BYTE_W-1:0]         rdata_o,
  input  logic [WORD_W-1:0]         cnt_i,
  output logic                      cnt_load_o,
  output logic [WORD_W-1:0]         cnt_load_val_o,
  output logic [WORD_W-1:0]         cap_o,
  output logic [NUM_CMP*WORD_W-1:0] cmp_o
);
  reg_kind_e          kind;
  logic               hi;
  logic [NUM_CMP-1:0] cmp_sel;
  logic               valid_reg;
  logic               wr_hi, wr_lo, rd_lo;
  logic               temp_load;
  logic [BYTE_W-1:0]  temp_d, temp_q;
  logic [WORD_W-1:0]  word_d;
  logic [WORD_W-1:0]  cmp_rd;

  wrb_decode #(
    .NUM_CMP (NUM_CMP),
    .ADDR_W  (ADDR_W)
  ) i_decode (
    .addr_i    (addr_i),
    .kind_o    (kind),
    .hi_o      (hi),
    .cmp_sel_o (cmp_sel)
  );

  assign valid_reg = (kind != KIND_NONE);
  assign wr_hi     = wr_en_i && hi && valid_reg;
  assign wr_lo     = wr_en_i && !hi && valid_reg;
  // write strobe wins over a concurrent read
  assign rd_lo     = rd_en_i && !wr_en_i && !hi;
  assign word_d    = {temp_q, wdata_i};

  always_comb begin
    temp_load = 1'b0;
    temp_d    = wdata_i;
    if (wr_hi) begin
      temp_load = 1'b1;
    end else if (rd_lo && kind == KIND_CNT) begin
      temp_load = 1'b1;
      temp_d    = cnt_i[WORD_W-1:BYTE_W];
    end else if (rd_lo && kind == KIND_CAP) begin
      temp_load = 1'b1;
      temp_d    = cap_o[WORD_W-1:BYTE_W];
    end
  end

  wrb_temp_reg #(.W(BYTE_W)) i_temp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (temp_load),
    .d_i    (temp_d),
    .q_o    (temp_q)
  );

  wrb_store #(.W(WORD_W)) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_lo && kind == KIND_CAP),
    .d_i    (word_d),
    .q_o    (cap_o)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    wrb_store #(.W(WORD_W)) i_cmp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_lo && cmp_sel[k]),
      .d_i    (word_d),
      .q_o    (cmp_o[k*WORD_W +: WORD_W])
    );
  end

  assign cnt_load_o     = wr_lo && kind == KIND_CNT;
  assign cnt_load_val_o = word_d;

  always_comb begin
    cmp_rd = '0;
    for (int k = 0; k < NUM_CMP; k++) begin
      if (cmp_sel[k]) cmp_rd = cmp_rd | cmp_o[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (kind)
        KIND_CNT: rdata_o = hi ? temp_q : cnt_i[BYTE_W-1:0];
        KIND_CAP: rdata_o = hi ? temp_q : cap_o[BYTE_W-1:0];
        KIND_CMP: rdata_o = hi ? cmp_rd[WORD_W-1:BYTE_W] : cmp_rd[BYTE_W-1:0];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wrb_chk.sv
module wrb_chk #(
  parameter int unsigned NUM_CMP = 3,
  localparam int unsigned ADDR_W = $clog2(NUM_CMP + 2) + 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic                      rd_en_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [7:0]                wdata_i,
  input logic [15:0]               cnt_i,
  input logic                      cnt_load_o,
  input logic [15:0]               cap_o,
  input logic [NUM_CMP*16-1:0]     cmp_o,
  input logic [7:0]                temp_q
);
  logic [ADDR_W-2:0] a_idx;
  logic              a_hi, a_cmp, a_oor;

  assign a_idx = addr_i[ADDR_W-1:1];
  assign a_hi  = addr_i[0];
  assign a_cmp = int'(a_idx) >= 2 && int'(a_idx) < NUM_CMP + 2;
  assign a_oor = int'(a_idx) >= NUM_CMP + 2;

  // R2
  hi_write_keeps_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_hi) |=> (cap_o == $past(cap_o) && cmp_o == $past(cmp_o)));

  // R3
  cap_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !a_hi && a_idx == 1) |=> cap_o == {$past(temp_q), $past(wdata_i)});

  // R4
  cnt_snapshot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !a_hi && a_idx == 0) |=> temp_q == $past(cnt_i[15:8]));

  // R6
  cmp_read_keeps_temp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && a_cmp) |=> $stable(temp_q));

  // R9
  oor_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_oor) |=> ($stable(temp_q) && $stable(cap_o) && $stable(cmp_o)));

  // R10
  wr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_hi && !a_oor) |=> temp_q == $past(wdata_i));

  // R3
  load_only_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_o |-> (wr_en_i && !a_hi && a_idx == 0));
endmodule

bind wide_reg_bridge wrb_chk #(.NUM_CMP(NUM_CMP)) i_wrb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .cnt_i      (cnt_i),
  .cnt_load_o (cnt_load_o),
  .cap_o      (cap_o),
  .cmp_o      (cmp_o),
  .temp_q     (temp_q)
);

// File: tb/test_wide_reg_bridge.sv
`timescale 1ns/1ps
module test_wide_reg_bridge;
  localparam int NC = 3;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [15:0]   cnt = '0;
  logic          cnt_load;
  logic [15:0]   cnt_load_val;
  logic [15:0]   cap;
  logic [NC*16-1:0] cmp;

  int checks = 0, failures = 0;
  logic [7:0]  m_temp = '0;
  logic [15:0] m_reg [0:NC];   // 0 = capture, 1+k = compare k
  logic        done = 1'b0;

  always #2 clk = ~clk;

  wide_reg_bridge #(.NUM_CMP(NC)) i_wide_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt),
    .cnt_load_o(cnt_load), .cnt_load_val_o(cnt_load_val),
    .cap_o(cap), .cmp_o(cmp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [AW-1:0] a);
    int idx = int'(a >> 1);
    logic h = a[0];
    if (idx == 0) return h ? m_temp : cnt[7:0];
    if (idx == 1) return h ? m_temp : m_reg[0][7:0];
    if (idx < NC + 2) return h ? m_reg[idx-1][15:8] : m_reg[idx-1][7:0];
    return 8'h00;
  endfunction

  task automatic check_regs(input string tag);
    check({tag, " cap"}, 32'(cap), 32'(m_reg[0]));
    for (int k = 0; k < NC; k++)
      check({tag, " cmp"}, 32'(cmp[k*16 +: 16]), 32'(m_reg[k+1]));
  endtask

  // one bus cycle; both strobes may be set
  task automatic bus(input logic w, input logic r, input logic [AW-1:0] a,
                     input logic [7:0] d, input string tag);
    int idx = int'(a >> 1);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    if (r) check({tag, " rdata"}, 32'(rdata), 32'(exp_rd(a)));
    else   check("R10 rdata idle", 32'(rdata), 32'h0);
    if (w && !a[0] && idx == 0) begin
      check("R3 cnt_load", 32'(cnt_load), 32'h1);
      check("R3 cnt_load_val", 32'(cnt_load_val), 32'({m_temp, d}));
    end else begin
      check("R3 no cnt_load", 32'(cnt_load), 32'h0);
    end
    @(posedge clk);
    if (w) begin
      if (idx < NC + 2) begin
        if (a[0]) m_temp = d;
        else if (idx >= 1) m_reg[idx-1] = {m_temp, d};
      end
    end else if (r && !a[0]) begin
      if (idx == 0) m_temp = cnt[15:8];
      else if (idx == 1) m_temp = m_reg[0][15:8];
    end
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    check_regs(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    for (int i = 0; i <= NC; i++) m_reg[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    check_regs("R1 reset");
    check("R1 cnt_load reset", 32'(cnt_load), 32'h0);
    rst_n = 1'b1;
    // R1: holding register reads zero after reset
    bus(1'b0, 1'b1, 4'h1, 8'h00, "R1 temp reset");

    // R2/R3/R5/R6: sweep every index and both bytes with a write pair then reads
    for (int idx = 0; idx < 8; idx++) begin
      for (int v = 0; v < 4; v++) begin
        logic [7:0] hb = 8'(idx * 37 + v * 91 + 5);
        logic [7:0] lb = 8'(idx * 53 + v * 29 + 11);
        cnt = 16'(idx * 4099 + v * 613);
        bus(1'b1, 1'b0, 4'(idx*2+1), hb, "R2 hi write");
        bus(1'b1, 1'b0, 4'(idx*2),   lb, idx >= NC+2 ? "R9 oor write" : "R3 lo write");
        bus(1'b0, 1'b1, 4'(idx*2),   8'h0, idx >= 2 ? "R6 lo read" : "R5 lo read");
        cnt = cnt + 16'h0101;
        bus(1'b0, 1'b1, 4'(idx*2+1), 8'h0, idx >= NC+2 ? "R9 hi read" : "R4 hi read");
      end
    end

    // R4: snapshot survives live counter change
    cnt = 16'hA55A;
    bus(1'b0, 1'b1, 4'h0, 8'h0, "R4 cnt lo");
    cnt = 16'h1234;
    bus(1'b0, 1'b1, 4'h1, 8'h0, "R4 cnt hi snapshot");
    check("R4 snapshot value", 32'(m_temp), 32'hA5);

    // R7: high byte via compare 0, low byte commits compare 2 and capture
    bus(1'b1, 1'b0, 4'h5, 8'hC3, "R7 hi via cmp0");
    bus(1'b1, 1'b0, 4'h8, 8'h3C, "R7 lo into cmp2");
    check("R7 cmp2", 32'(cmp[2*16 +: 16]), 32'hC33C);
    // R8: second low write reuses same high byte
    bus(1'b1, 1'b0, 4'h2, 8'h77, "R8 lo into cap");
    check("R8 cap", 32'(cap), 32'hC377);

    // R9: out-of-range high write leaves holding register alone
    bus(1'b1, 1'b0, 4'hF, 8'hEE, "R9 oor hi");
    bus(1'b1, 1'b0, 4'h4, 8'h01, "R9 probe cmp0");
    check("R9 cmp0 high kept", 32'(cmp[15:8]), 32'hC3);

    // R10: read low of counter together with high write; write wins
    cnt = 16'h9900;
    bus(1'b1, 1'b1, 4'h3, 8'h42, "R10 wr hi");
    bus(1'b1, 1'b1, 4'h0, 8'h10, "R10 wr lo cnt + rd");
    bus(1'b0, 1'b1, 4'h1, 8'h0, "R10 temp after both");
    check("R10 temp", 32'(m_temp), 32'h42);

    // pseudo-random accesses against the model
    for (int n = 0; n < 1500; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      cnt = lcg[31:16];
      bus(lcg[3], lcg[4] | ~lcg[3], lcg[8:5], lcg[16:9], "R2-model random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule